// File: doc/BRIEF.md
# Cross-Bank Burst Interrupt and Deferred Precharge Tracker

This block sits next to the command sequencer of an SDRAM controller. Each clock it sees the command the controller issues: a read, a write or a burst halt, with a bank number and an auto-precharge flag. From that stream it works out which bank owns the data bus in each cycle. Read beats appear after the configured CAS latency, and write beats are sampled in the cycle of issue. When an access to another bank cuts a burst short, the new burst takes over the bus. The tracker also reports how many clocks of DQM masking the controller must place ahead of a write that would cut into the current read.

The block keeps the deferred auto precharge of a burst that was cut short. A bank that was reading with auto precharge gets its precharge start in the same clock as the command that interrupts it. A bank that was writing with auto precharge first waits out the write-recovery count, which starts in that same clock. A burst that nobody interrupts runs its full length and then closes by the same rules. Commands that break these rules are flagged with a one-clock pulse and have no effect.

Top module: `sdram_burst_interrupt_tracker`

## Requirements
- R1: After a synchronous active-high reset with no command presented, rd_en, wr_en, illegal_cmd and precharge_start are all 0 and dqm_lead is 0.
- R2: A legal write (cmd_op = 2) issued in cycle t raises wr_en with wr_bank equal to its bank in cycles t through t+BURST_LEN-1, as long as nothing interrupts it.
- R3: A legal read (cmd_op = 1) issued in cycle t raises rd_en with rd_bank equal to its bank in cycles t+cas_lat through t+cas_lat+BURST_LEN-1, as long as nothing interrupts it.
- R4: A legal read to another bank issued in cycle t, during a read burst, ends the old bank's read data at cycle t+cas_lat-1. The new bank's data follows from cycle t+cas_lat.
- R5: A legal write issued in cycle t drops rd_en from cycle t on, cancels all read data still in flight, and drives wr_en for the new bank in cycle t. rd_en and wr_en are never high together.
- R6: When a legal read or write interrupts a write burst in cycle t, the old bank's last wr_en beat is cycle t-1. In cycle t wr_en belongs to the new write, or is low for a read.
- R7: dqm_lead is 0 when no read burst is active, 1 when the active read burst has no auto precharge, and 2 when it has auto precharge.
- R8: For a read burst with auto precharge (cmd_ap = 1), its bank's precharge_start bit pulses in the clock that a legal read or write interrupts it. If nothing interrupts it, the pulse comes in the clock after its last issue beat.
- R9: For a write burst with auto precharge, its bank's precharge_start bit pulses wr_rec clocks after the clock that ends it. That clock is the interrupting legal command, or the clock after its last beat.
- R10: A burst halt (cmd_op = 3) to the bank of an active burst with beats left ends that burst with no beat in that clock. A halt to any other bank, or with no burst left, pulses illegal_cmd and changes nothing.
- R11: A read or write to a bank that is waiting out write recovery, or to the bank of an active auto-precharge burst, pulses illegal_cmd and is ignored. cmd_op = 0 is no operation, and illegal_cmd never pulses without cmd_valid.
- R12: Each precharge_start bit is high for exactly one clock per deferred precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 2 | Static CAS latency, 2 or 3 |
| wr_rec | input | 2 | Static write-recovery cycles, 1 to 3 |
| cmd_valid | input | 1 | A command is issued this clock |
| cmd_op | input | 2 | 0 none, 1 read, 2 write, 3 burst halt |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto precharge with this read or write |
| rd_en | output | 1 | Read data is on the bus this clock |
| rd_bank | output | 2 | Bank owning the read data |
| wr_en | output | 1 | Write data is sampled this clock |
| wr_bank | output | 2 | Bank receiving the write data |
| dqm_lead | output | 2 | Clocks of DQM masking required before an interrupting write |
| precharge_start | output | 4 | Per-bank one-clock deferred precharge start |
| illegal_cmd | output | 1 | One-clock pulse on an illegal command |

## Verification
Two events can land in one clock: the interrupting command starts a new burst, and the interrupted bank's deferred precharge begins in that same clock. A write-recovery countdown of some other bank can also fire then. The bench provokes this with back-to-back accesses to alternating banks with auto precharge, and with random traffic under every CAS latency and recovery setting. A cycle model in the bench predicts the bus owner, the mask lead and the full precharge vector for each clock, and every clock is compared against it. A handful of directed sequences pin down the exact clock in which a read with auto precharge is cut off, the clock in which a write with auto precharge is cut off, and illegal halts.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2,
      OP_HALT = 2'd3
   } sdt_op_e;

   // Mask-lead codes reported ahead of a write that cuts into a read.
   localparam logic [1:0] LEAD_NONE = 2'd0;
   localparam logic [1:0] LEAD_ONE  = 2'd1;
   localparam logic [1:0] LEAD_TWO  = 2'd2;

endpackage

// File: rtl/sdt_read_pipe.sv
module sdt_read_pipe #(
   parameter int DEPTH  = 3,
   parameter int BANK_W = 2,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [SEL_W-1:0]  tap_sel,
   output logic              out_valid,
   output logic [BANK_W-1:0] out_bank
);

   logic [DEPTH-1:0]  stg_v;
   logic [BANK_W-1:0] stg_b [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst || flush) begin
               stg_v[0] <= 1'b0;
               stg_b[0] <= '0;
            end else begin
               stg_v[0] <= in_valid;
               stg_b[0] <= in_bank;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst || flush) begin
               stg_v[i] <= 1'b0;
               stg_b[i] <= '0;
            end else begin
               stg_v[i] <= stg_v[i-1];
               stg_b[i] <= stg_b[i-1];
            end
         end
      end
   end

   // A latency of L selects the stage holding the beat issued L clocks ago.
   int tap_idx;
   always_comb begin
      if (int'(tap_sel) == 0)
         tap_idx = 0;
      else if (int'(tap_sel) > DEPTH)
         tap_idx = DEPTH - 1;
      else
         tap_idx = int'(tap_sel) - 1;
      out_valid = stg_v[tap_idx];
      out_bank  = stg_b[tap_idx];
   end

endmodule

// File: rtl/sdt_wr_recovery.sv
module sdt_wr_recovery #(
   parameter int REC_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [REC_W-1:0] rec_cycles,
   output logic             busy,
   output logic             fire
);

   logic [REC_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (start)
         cnt_q <= (rec_cycles == '0) ? REC_W'(1) : rec_cycles;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - REC_W'(1);
   end

   assign busy = (cnt_q != '0);
   assign fire = (cnt_q == REC_W'(1));

endmodule

// File: rtl/sdt_burst_core.sv
module sdt_burst_core
   import sdt_pkg::*;
#(
   parameter  int NUM_BANKS = 4,
   parameter  int BURST_LEN = 4,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cmd_valid,
   input  sdt_op_e              cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   input  logic [NUM_BANKS-1:0] bank_recovering,
   output logic                 rd_issue,
   output logic                 wr_beat,
   output logic [BANK_W-1:0]    beat_bank,
   output logic                 wr_cmd_taken,
   output logic [1:0]           dqm_lead,
   output logic [NUM_BANKS-1:0] ap_read_done,
   output logic [NUM_BANKS-1:0] rec_start,
   output logic                 illegal_cmd
);

   localparam int REM_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

   logic              act_q, act_wr_q, act_ap_q;
   logic [BANK_W-1:0] act_bank_q;
   logic [REM_W-1:0]  rem_q;

   logic is_rw, is_halt, bank_locked, take_rw, take_halt;
   logic burst_ends, old_beat, has_rem;

   always_comb begin
      has_rem     = (rem_q != '0);
      is_rw       = cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR);
      is_halt     = cmd_valid && (cmd_op == OP_HALT);
      bank_locked = bank_recovering[cmd_bank] ||
                    (act_q && act_ap_q && act_bank_q == cmd_bank);
      take_rw     = is_rw && !bank_locked;
      take_halt   = is_halt && act_q && has_rem && act_bank_q == cmd_bank;
      illegal_cmd = (is_rw && bank_locked) || (is_halt && !take_halt);

      // Interruption, halt and natural completion close a burst alike.
      burst_ends  = act_q && (take_rw || take_halt || !has_rem);
      old_beat    = act_q && has_rem && !take_rw && !take_halt;

      rd_issue     = (take_rw && cmd_op == OP_RD) || (old_beat && !act_wr_q);
      wr_beat      = (take_rw && cmd_op == OP_WR) || (old_beat && act_wr_q);
      beat_bank    = take_rw ? cmd_bank : act_bank_q;
      wr_cmd_taken = take_rw && cmd_op == OP_WR;

      if (act_q && !act_wr_q)
         dqm_lead = act_ap_q ? LEAD_TWO : LEAD_ONE;
      else
         dqm_lead = LEAD_NONE;

      ap_read_done = '0;
      rec_start    = '0;
      if (burst_ends && act_ap_q) begin
         if (act_wr_q)
            rec_start[act_bank_q] = 1'b1;
         else
            ap_read_done[act_bank_q] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         act_q      <= 1'b0;
         act_wr_q   <= 1'b0;
         act_ap_q   <= 1'b0;
         act_bank_q <= '0;
         rem_q      <= '0;
      end else if (take_rw) begin
         act_q      <= 1'b1;
         act_wr_q   <= (cmd_op == OP_WR);
         act_ap_q   <= cmd_ap;
         act_bank_q <= cmd_bank;
         rem_q      <= REM_W'(BURST_LEN - 1);
      end else if (burst_ends) begin
         act_q      <= 1'b0;
         act_ap_q   <= 1'b0;
      end else if (old_beat) begin
         rem_q      <= rem_q - REM_W'(1);
      end
   end

endmodule

// File: rtl/sdram_burst_interrupt_tracker.sv
module sdram_burst_interrupt_tracker
   import sdt_pkg::*;
#(
   parameter  int NUM_BANKS   = 4,
   parameter  int BURST_LEN   = 4,
   parameter  int MAX_CAS_LAT = 3,
   parameter  int REC_W       = 2,
   localparam int BANK_W      = $clog2(NUM_BANKS),
   localparam int CL_W        = $clog2(MAX_CAS_LAT + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [CL_W-1:0]      cas_lat,
   input  logic [REC_W-1:0]     wr_rec,
   input  logic                 cmd_valid,
   input  logic [1:0]           cmd_op,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_ap,
   output logic                 rd_en,
   output logic [BANK_W-1:0]    rd_bank,
   output logic                 wr_en,
   output logic [BANK_W-1:0]    wr_bank,
   output logic [1:0]           dqm_lead,
   output logic [NUM_BANKS-1:0] precharge_start,
   output logic                 illegal_cmd
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (BURST_LEN < 1) begin : g_chk_bl
      $error("BURST_LEN must be at least 1");
   end
   if (MAX_CAS_LAT < 1) begin : g_chk_cl
      $error("MAX_CAS_LAT must be at least 1");
   end
   if (REC_W < 1) begin : g_chk_rec
      $error("REC_W must be at least 1");
   end

   logic                 rd_issue, wr_beat, wr_cmd_taken;
   logic [BANK_W-1:0]    beat_bank;
   logic [NUM_BANKS-1:0] recovering, rec_fire, rec_start, ap_read_done;
   logic                 pipe_valid;
   logic [BANK_W-1:0]    pipe_bank;

   sdt_burst_core #(
      .NUM_BANKS (NUM_BANKS),
      .BURST_LEN (BURST_LEN)
   ) u_core (
      .clk             (clk),
      .rst             (rst),
      .cmd_valid       (cmd_valid),
      .cmd_op          (sdt_op_e'(cmd_op)),
      .cmd_bank        (cmd_bank),
      .cmd_ap          (cmd_ap),
      .bank_recovering (recovering),
      .rd_issue        (rd_issue),
      .wr_beat         (wr_beat),
      .beat_bank       (beat_bank),
      .wr_cmd_taken    (wr_cmd_taken),
      .dqm_lead        (dqm_lead),
      .ap_read_done    (ap_read_done),
      .rec_start       (rec_start),
      .illegal_cmd     (illegal_cmd)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdt_wr_recovery #(
         .REC_W (REC_W)
      ) u_rec (
         .clk        (clk),
         .rst        (rst),
         .start      (rec_start[b]),
         .rec_cycles (wr_rec),
         .busy       (recovering[b]),
         .fire       (rec_fire[b])
      );
   end

   sdt_read_pipe #(
      .DEPTH  (MAX_CAS_LAT),
      .BANK_W (BANK_W),
      .SEL_W  (CL_W)
   ) u_rpipe (
      .clk       (clk),
      .rst       (rst),
      .flush     (wr_cmd_taken),
      .in_valid  (rd_issue),
      .in_bank   (beat_bank),
      .tap_sel   (cas_lat),
      .out_valid (pipe_valid),
      .out_bank  (pipe_bank)
   );

   // A write owns the bus from the clock it is registered.
   assign rd_en           = pipe_valid && !wr_cmd_taken;
   assign rd_bank         = pipe_bank;
   assign wr_en           = wr_beat;
   assign wr_bank         = beat_bank;
   assign precharge_start = ap_read_done | rec_fire;

endmodule

// File: rtl/sdram_burst_interrupt_tracker_chk.sv
module sdram_burst_interrupt_tracker_chk #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cmd_valid,
   input logic [1:0]           cmd_op,
   input logic                 rd_en,
   input logic                 wr_en,
   input logic [BANK_W-1:0]    wr_bank,
   input logic [1:0]           dqm_lead,
   input logic [NUM_BANKS-1:0] precharge_start,
   input logic                 illegal_cmd
);

   // R5: read and write data never share a clock
   a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && wr_en));

   // R2: a continuing write burst keeps its bank when no command arrives
   a_r2_wr_bank_hold: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !cmd_valid) |=> (wr_en && !cmd_valid) |-> $stable(wr_bank));

   // R8: a legal access cutting an auto-precharge read starts a precharge now
   a_r8_apread_cut_fires: assert property (@(posedge clk) disable iff (rst)
      (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2) && !illegal_cmd &&
       dqm_lead == 2'd2) |-> (precharge_start != '0));

   // R12: no precharge bit stays high two clocks in a row
   a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
      (precharge_start != '0) |=> ((precharge_start & $past(precharge_start)) == '0));

   // R11: no command means no illegal flag
   a_r11_no_cmd_no_flag: assert property (@(posedge clk) disable iff (rst)
      !cmd_valid |-> !illegal_cmd);

endmodule

bind sdram_burst_interrupt_tracker sdram_burst_interrupt_tracker_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W)
) u_chk (
   .clk             (clk),
   .rst             (rst),
   .cmd_valid       (cmd_valid),
   .cmd_op          (cmd_op),
   .rd_en           (rd_en),
   .wr_en           (wr_en),
   .wr_bank         (wr_bank),
   .dqm_lead        (dqm_lead),
   .precharge_start (precharge_start),
   .illegal_cmd     (illegal_cmd)
);

// File: tb/sdram_burst_interrupt_tracker_test.sv
module sdram_burst_interrupt_tracker_test;

   localparam int NB = 4;
   localparam int BL = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cas_lat = 2'd2;
   logic [1:0] wr_rec  = 2'd1;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [1:0] cmd_bank = 2'd0;
   logic       cmd_ap = 1'b0;
   logic       rd_en, wr_en, illegal_cmd;
   logic [1:0] rd_bank, wr_bank, dqm_lead;
   logic [NB-1:0] precharge_start;

   always #5 clk = ~clk;

   sdram_burst_interrupt_tracker uut (
      .clk(clk), .rst(rst), .cas_lat(cas_lat), .wr_rec(wr_rec),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
      .rd_en(rd_en), .rd_bank(rd_bank), .wr_en(wr_en), .wr_bank(wr_bank),
      .dqm_lead(dqm_lead), .precharge_start(precharge_start), .illegal_cmd(illegal_cmd)
   );

   int n_run = 0;
   int n_fail = 0;
   string tag = "R1";

   // Reference cycle model built from the requirements.
   bit       m_act, m_wr, m_ap;
   int       m_bank, m_rem;
   int       m_rec [NB];
   bit       h_v [4];
   int       h_b [4];

   task automatic model_reset();
      m_act = 0; m_wr = 0; m_ap = 0; m_bank = 0; m_rem = 0;
      for (int i = 0; i < NB; i++) m_rec[i] = 0;
      for (int i = 0; i < 4; i++) begin h_v[i] = 0; h_b[i] = 0; end
   endtask

   task automatic chk(string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cycle(bit v, int op, int bk, bit ap);
      bit rw, busy, lrw, stop, lstop, e_ill, endn, oldb, iss, e_wr, e_rd;
      int e_bank, e_dqm;
      logic [NB-1:0] e_pcs;
      @(negedge clk);
      cmd_valid = v; cmd_op = 2'(op); cmd_bank = 2'(bk); cmd_ap = ap;
      #4;
      rw     = v && (op == 1 || op == 2);
      busy   = (m_rec[bk] != 0) || (m_act && m_ap && m_bank == bk);
      lrw    = rw && !busy;
      stop   = v && op == 3;
      lstop  = stop && m_act && m_rem != 0 && m_bank == bk;
      e_ill  = (rw && busy) || (stop && !lstop);
      endn   = m_act && (lrw || lstop || m_rem == 0);
      oldb   = m_act && m_rem != 0 && !lrw && !lstop;
      e_bank = lrw ? bk : m_bank;
      e_wr   = (lrw && op == 2) || (oldb && m_wr);
      iss    = (lrw && op == 1) || (oldb && !m_wr);
      e_rd   = h_v[int'(cas_lat)] && !(lrw && op == 2);
      e_dqm  = (m_act && !m_wr) ? (m_ap ? 2 : 1) : 0;
      e_pcs  = '0;
      for (int i = 0; i < NB; i++) if (m_rec[i] == 1) e_pcs[i] = 1'b1;
      if (endn && m_ap && !m_wr) e_pcs[m_bank] = 1'b1;

      chk("illegal_cmd", int'(illegal_cmd), int'(e_ill));
      chk("wr_en", int'(wr_en), int'(e_wr));
      if (e_wr) chk("wr_bank", int'(wr_bank), e_bank);
      chk("rd_en", int'(rd_en), int'(e_rd));
      if (e_rd) chk("rd_bank", int'(rd_bank), h_b[int'(cas_lat)]);
      chk("dqm_lead", int'(dqm_lead), e_dqm);
      chk("precharge_start", int'(precharge_start), int'(e_pcs));

      for (int i = 0; i < NB; i++) begin
         if (endn && m_wr && m_ap && i == m_bank) m_rec[i] = (wr_rec == 0) ? 1 : int'(wr_rec);
         else if (m_rec[i] != 0) m_rec[i]--;
      end
      if (lrw && op == 2) begin
         for (int i = 0; i < 4; i++) h_v[i] = 0;
      end else begin
         for (int i = 3; i > 1; i--) begin h_v[i] = h_v[i-1]; h_b[i] = h_b[i-1]; end
         h_v[1] = iss; h_b[1] = e_bank;
      end
      if (lrw) begin
         m_act = 1; m_wr = (op == 2); m_ap = ap; m_bank = bk; m_rem = BL - 1;
      end else if (endn) begin
         m_act = 0; m_ap = 0;
      end else if (oldb) begin
         m_rem--;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle(0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cmd_valid = 0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      tag = "R1"; idle(3);

      for (int cl = 2; cl <= 3; cl++) begin
         for (int wrr = 1; wrr <= 3; wrr++) begin
            idle(10);
            cas_lat = 2'(cl); wr_rec = 2'(wrr);
            tag = "R2"; cycle(1, 2, 1, 0); idle(6);
            tag = "R3"; cycle(1, 1, 2, 0); idle(8);
            tag = "R4"; cycle(1, 1, 0, 0); cycle(0, 0, 0, 0); cycle(1, 1, 3, 0); idle(8);
            tag = "R5"; cycle(1, 1, 0, 1); cycle(0, 0, 0, 0); cycle(1, 2, 1, 0); idle(8);
            tag = "R6"; cycle(1, 2, 2, 0); cycle(0, 0, 0, 0); cycle(1, 1, 3, 0); idle(8);
            tag = "R7"; cycle(1, 1, 1, 0); cycle(1, 1, 2, 1); idle(8);
            tag = "R8"; cycle(1, 1, 0, 1); cycle(1, 1, 1, 1); cycle(1, 2, 2, 0); idle(8);
            tag = "R9"; cycle(1, 2, 3, 1); cycle(0, 0, 0, 0); cycle(1, 2, 0, 1); idle(10);
            tag = "R10"; cycle(1, 3, 1, 0); cycle(1, 2, 2, 0); cycle(1, 3, 0, 0);
            cycle(1, 3, 2, 0); cycle(1, 3, 2, 0); idle(8);
            tag = "R11"; cycle(1, 2, 1, 1); cycle(1, 1, 1, 0); cycle(1, 2, 0, 0);
            cycle(1, 2, 1, 0); idle(8);
            tag = "R12";
            for (int k = 0; k < 300; k++) begin
               int r, op, bk;
               bit v, ap;
               r  = int'($urandom_range(0, 99));
               v  = (r < 70);
               op = (r < 8) ? 3 : ((r < 40) ? 1 : 2);
               bk = int'($urandom_range(0, NB - 1));
               ap = ($urandom_range(0, 9) < 3);
               cycle(v, op, bk, ap);
            end
         end
      end
      idle(10);
      tag = "R1"; do_reset(); idle(2);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule